// File: doc/BRIEF.md
# Destination-Routed Status Flag Unit

This block holds a 17-bit processor status word and the logic that keeps its flags current. Each cycle the datapath may present a result value with its carry and overflow indications, along with a code that says where the result is going: an accumulator, an address register, or the internal data bus. Only the flag group owned by that destination is refreshed. The other groups, and the mode bits, keep their values. Three separate groups of sign, zero and carry information are kept, and the destination code alone selects which group changes. The opcode plays no part in that choice.

The lowest five bits are mode bits. Each one can be set or cleared on its own by a per-bit command. Software saves and restores context through a full-word write port and the always-visible status output. The arithmetic unit, the meaning of the modes and branch evaluation all sit outside the block. The flags are simply exported on the status output.

Top module: `stat_flag_unit`

## Requirements
- R1: After reset, the status output reads 17'h00000, and it stays at that value until the first write, mode command or flag update.
- R2: The bit layout is fixed as follows. Bits [4:0] hold the modes. Bits 6 and 5 always read 0. The accumulator group uses bit 7 for sign, bit 8 for zero, bit 9 for carry and bit 10 for overflow. The address group uses bit 11 for zero and bit 12 for carry. The bus group uses bit 13 for sign and bit 14 for zero. Bits 16 and 15 are software condition bits.
- R3: For each mode bit i, mode_set[i] sets it and mode_clr[i] clears it, with no effect on any other bit. When both are asserted in the same cycle, the clear wins.
- R4: With upd_valid high and upd_dest = 2'b00 (accumulator), these flags are loaded on the next edge: bit 7 from res_value[ACC_W-1], bit 8 from (res_value == 0), bit 9 from res_carry and bit 10 from res_ovf. Bits 16:11 are unchanged.
- R5: With upd_valid high and upd_dest = 2'b01 (address register), these flags are loaded: bit 11 from (res_value[ADDR_W-1:0] == 0) and bit 12 from res_carry. Bits 10:7 and 16:13 are unchanged.
- R6: With upd_valid high and upd_dest = 2'b10 (data bus), these flags are loaded: bit 13 from res_value[BUS_W-1] and bit 14 from (res_value[BUS_W-1:0] == 0). Bits 12:7 and 16:15 are unchanged.
- R7: When upd_valid is low, or when upd_dest = 2'b11, bits 16:7 do not change.
- R8: When wr_en is high, every implemented bit is loaded from wr_data on the next edge. This write takes priority over any flag update and any mode command in the same cycle.
- R9: Bits 6:5 ignore the written data. Bits 16:15 change only through a full-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_valid | input | 1 | A result is present this cycle |
| upd_dest | input | 2 | Destination of the result: 00 accumulator, 01 address register, 10 data bus, 11 none |
| res_value | input | ACC_W | Result value |
| res_carry | input | 1 | Carry-out of the result |
| res_ovf | input | 1 | Overflow of the result |
| mode_set | input | 5 | Per-bit mode set commands |
| mode_clr | input | 5 | Per-bit mode clear commands |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 17 | Full-word write data |
| stat_q | output | 17 | Current status word |

## Verification
The hardest case to reach from the ports is a cycle in which several sources compete: a full-word write arriving together with a flag update and mode commands, or a set and a clear aimed at the same mode bit. Directed cycles build these collisions on purpose, starting from an all-ones word so that any wrongly kept or wrongly changed bit shows up. A long biased random run then follows, with frequent zero results, all four destination codes and sparse overlapping mode masks. A behavioural model checks every cycle of it.

// File: rtl/stat_flag_pkg.sv
package stat_flag_pkg;
  localparam int STAT_W = 17;
  localparam int MODE_N = 5;

  localparam int POS_ACC_SIGN  = 7;
  localparam int POS_ACC_ZERO  = 8;
  localparam int POS_ACC_CARRY = 9;
  localparam int POS_ACC_OVF   = 10;
  localparam int POS_ADR_ZERO  = 11;
  localparam int POS_ADR_CARRY = 12;
  localparam int POS_BUS_SIGN  = 13;
  localparam int POS_BUS_ZERO  = 14;

  // Bits 6:5 are not implemented
  localparam logic [STAT_W-1:0] IMPL_MASK = 17'h1FF9F;

  typedef enum logic [1:0] {
    DST_ACC  = 2'b00,
    DST_ADDR = 2'b01,
    DST_BUS  = 2'b10,
    DST_NONE = 2'b11
  } dest_e;

  typedef struct packed {
    logic acc_en;
    logic adr_en;
    logic bus_en;
    logic acc_sign;
    logic acc_zero;
    logic acc_carry;
    logic acc_ovf;
    logic adr_zero;
    logic adr_carry;
    logic bus_sign;
    logic bus_zero;
  } flag_upd_t;
endpackage

// File: rtl/stat_flag_eval.sv
module stat_flag_eval
  import stat_flag_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic             upd_valid,
  input  logic [1:0]       upd_dest,
  input  logic [ACC_W-1:0] res_value,
  input  logic             res_carry,
  input  logic             res_ovf,
  output flag_upd_t        upd_o
);
  dest_e dest;

  always_comb begin
    dest = dest_e'(upd_dest);
    upd_o = '0;
    upd_o.acc_en    = upd_valid && (dest == DST_ACC);
    upd_o.adr_en    = upd_valid && (dest == DST_ADDR);
    upd_o.bus_en    = upd_valid && (dest == DST_BUS);
    upd_o.acc_sign  = res_value[ACC_W-1];
    upd_o.acc_zero  = (res_value == '0);
    upd_o.acc_carry = res_carry;
    upd_o.acc_ovf   = res_ovf;
    upd_o.adr_zero  = (res_value[ADDR_W-1:0] == '0);
    upd_o.adr_carry = res_carry;
    upd_o.bus_sign  = res_value[BUS_W-1];
    upd_o.bus_zero  = (res_value[BUS_W-1:0] == '0);
  end
endmodule

// File: rtl/stat_mode_ctl.sv
module stat_mode_ctl #(
  parameter int MODE_N = 5
) (
  input  logic [MODE_N-1:0] mode_cur,
  input  logic [MODE_N-1:0] mode_set,
  input  logic [MODE_N-1:0] mode_clr,
  output logic [MODE_N-1:0] mode_nxt
);
  for (genvar gi = 0; gi < MODE_N; gi++) begin : g_mode
    always_comb begin
      if (mode_clr[gi])      mode_nxt[gi] = 1'b0;
      else if (mode_set[gi]) mode_nxt[gi] = 1'b1;
      else                   mode_nxt[gi] = mode_cur[gi];
    end
  end
endmodule

// File: rtl/stat_reg_core.sv
module stat_reg_core
  import stat_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [MODE_N-1:0] mode_nxt,
  input  flag_upd_t         upd_i,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_r;
  logic [STAT_W-1:0] stat_nxt;
  logic              ld_en;

  always_comb begin
    stat_nxt = stat_r;
    if (wr_en) begin
      stat_nxt = wr_data;
    end else begin
      stat_nxt[MODE_N-1:0] = mode_nxt;
      if (upd_i.acc_en) begin
        stat_nxt[POS_ACC_SIGN]  = upd_i.acc_sign;
        stat_nxt[POS_ACC_ZERO]  = upd_i.acc_zero;
        stat_nxt[POS_ACC_CARRY] = upd_i.acc_carry;
        stat_nxt[POS_ACC_OVF]   = upd_i.acc_ovf;
      end
      if (upd_i.adr_en) begin
        stat_nxt[POS_ADR_ZERO]  = upd_i.adr_zero;
        stat_nxt[POS_ADR_CARRY] = upd_i.adr_carry;
      end
      if (upd_i.bus_en) begin
        stat_nxt[POS_BUS_SIGN]  = upd_i.bus_sign;
        stat_nxt[POS_BUS_ZERO]  = upd_i.bus_zero;
      end
    end
    stat_nxt = stat_nxt & IMPL_MASK;
  end

  assign ld_en = wr_en | upd_i.acc_en | upd_i.adr_en | upd_i.bus_en |
                 (mode_nxt != stat_r[MODE_N-1:0]);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  stat_r <= '0;
    else if (ld_en)   stat_r <= stat_nxt;
  end

  assign stat_q = stat_r;
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import stat_flag_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int ADDR_W      = 16,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [1:0]       upd_dest,
  input  logic [ACC_W-1:0] res_value,
  input  logic             res_carry,
  input  logic             res_ovf,
  input  logic [4:0]       mode_set,
  input  logic [4:0]       mode_clr,
  input  logic             wr_en,
  input  logic [16:0]      wr_data,
  output logic [16:0]      stat_q
);
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_core_n;
  flag_upd_t              upd;
  logic [MODE_N-1:0]      mode_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync[SYNC_STAGES-1];

  stat_flag_eval #(
    .ACC_W (ACC_W),
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W)
  ) u_eval (
    .upd_valid(upd_valid),
    .upd_dest (upd_dest),
    .res_value(res_value),
    .res_carry(res_carry),
    .res_ovf  (res_ovf),
    .upd_o    (upd)
  );

  stat_mode_ctl #(
    .MODE_N(MODE_N)
  ) u_mode (
    .mode_cur(stat_q[MODE_N-1:0]),
    .mode_set(mode_set),
    .mode_clr(mode_clr),
    .mode_nxt(mode_nxt)
  );

  stat_reg_core u_core (
    .clk       (clk),
    .rst_core_n(rst_core_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mode_nxt  (mode_nxt),
    .upd_i     (upd),
    .stat_q    (stat_q)
  );
endmodule

// File: rtl/stat_flag_chk.sv
module stat_flag_chk #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic [1:0]       upd_dest,
  input logic [ACC_W-1:0] res_value,
  input logic             res_carry,
  input logic             res_ovf,
  input logic [4:0]       mode_set,
  input logic [4:0]       mode_clr,
  input logic             wr_en,
  input logic [16:0]      wr_data,
  input logic [16:0]      stat_q
);
  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[6:5] == 2'b00);

  // R8
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stat_q == ($past(wr_data) & 17'h1FF9F));

  // R4
  acc_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_dest == 2'b00 && !wr_en) |=>
      (stat_q[7] == $past(res_value[ACC_W-1]) && stat_q[9] == $past(res_carry) &&
       stat_q[10] == $past(res_ovf) && stat_q[16:11] == $past(stat_q[16:11])));

  // R5
  adr_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_dest == 2'b01 && !wr_en) |=>
      (stat_q[12] == $past(res_carry) && stat_q[10:7] == $past(stat_q[10:7]) &&
       stat_q[16:13] == $past(stat_q[16:13])));

  // R6
  bus_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_dest == 2'b10 && !wr_en) |=>
      (stat_q[13] == $past(res_value[BUS_W-1]) && stat_q[12:7] == $past(stat_q[12:7]) &&
       stat_q[16:15] == $past(stat_q[16:15])));

  // R7
  no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (!upd_valid || upd_dest == 2'b11)) |=> $stable(stat_q[16:7]));

  // R3
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (|mode_clr)) |=> ((stat_q[4:0] & $past(mode_clr)) == 5'b0));

  // R3
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat_q[4:0] & $past(mode_set & ~mode_clr)) == $past(mode_set & ~mode_clr)));
endmodule

bind stat_flag_unit stat_flag_chk #(
  .ACC_W (ACC_W),
  .ADDR_W(ADDR_W),
  .BUS_W (BUS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .upd_valid(upd_valid),
  .upd_dest (upd_dest),
  .res_value(res_value),
  .res_carry(res_carry),
  .res_ovf  (res_ovf),
  .mode_set (mode_set),
  .mode_clr (mode_clr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .stat_q   (stat_q)
);

// File: tb/stat_flag_unit_tb.sv
module stat_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid;
  logic [1:0]  upd_dest;
  logic [15:0] res_value;
  logic        res_carry;
  logic        res_ovf;
  logic [4:0]  mode_set;
  logic [4:0]  mode_clr;
  logic        wr_en;
  logic [16:0] wr_data;
  logic [16:0] stat_q;

  int total = 0;
  int bad   = 0;
  logic [16:0] model = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stat_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_dest(upd_dest),
    .res_value(res_value), .res_carry(res_carry), .res_ovf(res_ovf),
    .mode_set(mode_set), .mode_clr(mode_clr), .wr_en(wr_en),
    .wr_data(wr_data), .stat_q(stat_q)
  );

  function automatic logic [16:0] predict(logic [16:0] cur);
    logic [16:0] n;
    if (wr_en) begin
      n = wr_data;
      n[6] = 1'b0;
      n[5] = 1'b0;
      return n;
    end
    n = cur;
    for (int i = 0; i < 5; i++) begin
      if (mode_clr[i])      n[i] = 1'b0;
      else if (mode_set[i]) n[i] = 1'b1;
    end
    if (upd_valid) begin
      case (upd_dest)
        2'd0: begin
          n[7]  = res_value[15];
          n[8]  = (res_value == 16'd0);
          n[9]  = res_carry;
          n[10] = res_ovf;
        end
        2'd1: begin
          n[11] = (res_value == 16'd0);
          n[12] = res_carry;
        end
        2'd2: begin
          n[13] = res_value[15];
          n[14] = (res_value == 16'd0);
        end
        default: ;
      endcase
    end
    return n;
  endfunction

  function automatic string tag_of();
    if (wr_en)                                 return "R8";
    if (upd_valid && upd_dest == 2'd0)         return "R4";
    if (upd_valid && upd_dest == 2'd1)         return "R5";
    if (upd_valid && upd_dest == 2'd2)         return "R6";
    if ((mode_set | mode_clr) != 5'd0)         return "R3";
    return "R7";
  endfunction

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_valid = 1'b0; upd_dest = 2'd3; res_value = '0; res_carry = 1'b0;
    res_ovf = 1'b0; mode_set = '0; mode_clr = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  // Inputs already driven at a falling edge; advance one cycle and compare
  task automatic cyc();
    string tag;
    tag = tag_of();
    @(posedge clk);
    model = predict(model);
    @(negedge clk);
    check(tag, stat_q, model);
  endtask

  task automatic drive(logic v, logic [1:0] d, logic [15:0] r, logic c, logic o,
                       logic [4:0] s, logic [4:0] k, logic w, logic [16:0] wd);
    upd_valid = v; upd_dest = d; res_value = r; res_carry = c; res_ovf = o;
    mode_set = s; mode_clr = k; wr_en = w; wr_data = wd;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset value
    check("R1", stat_q, 17'h00000);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    check("R1", stat_q, 17'h00000);

    // R8 + R2 + R9: write all ones, unused bits read zero, cond bits loaded
    drive(0, 2'd3, 16'h0, 0, 0, 5'h00, 5'h00, 1, 17'h1FFFF);
    check("R2", stat_q, 17'h1FF9F);
    check("R9", {15'd0, stat_q[16:15]}, 17'd3);

    // R4: accumulator result 0x8000, carry, no overflow
    drive(1, 2'd0, 16'h8000, 1, 0, 5'h00, 5'h00, 0, 17'h0);
    check("R4", stat_q, 17'h1FA9F);

    // R5: address result zero, no carry
    drive(1, 2'd1, 16'h0000, 0, 0, 5'h00, 5'h00, 0, 17'h0);
    check("R5", stat_q[12:11], 2'b01);

    // R6: bus result positive nonzero
    drive(1, 2'd2, 16'h0001, 1, 1, 5'h00, 5'h00, 0, 17'h0);
    check("R6", stat_q[14:13], 2'b00);

    // R7: destination none leaves flags alone
    drive(1, 2'd3, 16'h0000, 1, 1, 5'h00, 5'h00, 0, 17'h0);
    drive(0, 2'd0, 16'h0000, 1, 1, 5'h00, 5'h00, 0, 17'h0);

    // R3: set and clear same bit, clear wins; others untouched
    drive(0, 2'd3, 16'h0, 0, 0, 5'h00, 5'h1F, 0, 17'h0);
    check("R3", {12'd0, stat_q[4:0]}, 17'h0);
    drive(0, 2'd3, 16'h0, 0, 0, 5'h15, 5'h04, 0, 17'h0);
    check("R3", {12'd0, stat_q[4:0]}, 17'h11);

    // R8: write collides with update and mode commands
    drive(1, 2'd0, 16'h0000, 1, 1, 5'h1F, 5'h00, 1, 17'h18060);
    check("R8", stat_q, 17'h18000);

    // R9: updates of every destination never touch cond bits
    drive(1, 2'd0, 16'hFFFF, 0, 0, 5'h00, 5'h00, 0, 17'h0);
    drive(1, 2'd1, 16'h1234, 1, 0, 5'h00, 5'h00, 0, 17'h0);
    drive(1, 2'd2, 16'h0000, 0, 0, 5'h00, 5'h00, 0, 17'h0);
    check("R9", {15'd0, stat_q[16:15]}, 17'd3);

    // Random biased run
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] r;
      r = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
      drive($urandom_range(0, 3) != 0, 2'($urandom), r, 1'($urandom), 1'($urandom),
            5'($urandom & $urandom), 5'($urandom & $urandom),
            $urandom_range(0, 9) == 0, 17'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule